// File: doc/BRIEF.md
# Programmable Two-Channel Serial Audio Input Receiver

The receiver takes a two-channel serial audio stream as three wires: a bit clock, a left/right word clock and a data line. It samples all three with the system clock through a short synchroniser and detects the active bit-clock edge. It counts bit positions inside each word-clock phase and cuts one data word out of a programmable window in every phase. Consecutive words are grouped into couples, and each couple appears on two parallel 32-bit outputs with a one-cycle valid strobe.

Software sets up the framing through a small write port with two registers. The format register holds five control flags: bit order, one-bit sync offset, word-clock polarity, a start value for couple grouping, and the sampling edge. The layout register holds a 5-bit length field and a 5-bit window position field. Writing either register makes the receiver drop any half-built couple and wait for the next word-clock edge before it captures again.

Top module: `serial_audio_rx`

## Requirements
- R1: With format bit 4 at 0, the data and word clock are sampled on the rising bit-clock edge. With it at 1, they are sampled on the falling edge.
- R2: With format bit 0 at 0, words arrive least significant bit first. With it at 1, they arrive most significant bit first.
- R3: With format bit 1 at 0, the bit sampled on the edge where the word clock changes is phase index 0. With it at 1, that bit is ignored and the next bit is index 0.
- R4: The first captured index is layout bits [9:5] when most significant bit first. It is 31 minus that field when least significant bit first.
- R5: Layout bits [4:0] hold the word length minus one (1 to 32 bits). Each output word is right-justified, with zeros above its top bit.
- R6: Format bit 2 (word-clock polarity) and format bit 3 (start value) set the grouping. Words are numbered from 0 after each resync. When the two bits are equal, couples are (1,2), (3,4) and so on. When they differ, couples are (0,1), (2,3) and so on.
- R7: Within a couple, the word from the phase whose word-clock level equals format bit 2 goes to the left output, and the other word goes to the right output.
- R8: Data bits outside the configured window of a phase have no effect on the outputs.
- R9: A configuration write discards any half-built couple. Capture restarts at the next word-clock edge, and no valid pulse occurs in the cycle after the write.
- R10: After reset, all configuration fields are zero, both outputs are zero and valid is low. The all-zero setup captures a 1-bit word at index 31 of each phase.
- R11: Valid is high for exactly one cycle per couple, and both outputs hold their values between pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bckIn | input | 1 | Serial bit clock |
| lrckIn | input | 1 | Left/right word clock |
| sdataIn | input | 1 | Serial data |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0 selects the format register, 1 selects the layout register |
| cfgData | input | 10 | Write data; format uses bits [4:0], layout uses [4:0] length-1 and [9:5] position |
| validOut | output | 1 | One-cycle strobe for a new couple |
| leftOut | output | 32 | Left sample, right-justified |
| rightOut | output | 32 | Right sample, right-justified |

## Verification
A bit counter that is off by one, or a window start that is computed wrongly, shifts or scrambles every captured word. The error shows in the values at the very next valid pulse, at most two word-clock phases later. A wrong grouping parity, or a wrong left/right decision, shows as swapped samples or a word landing in the wrong couple on that same first pulse. A resync that fails to clear state shows as a stale word in the first couple after a configuration write. A polarity mismatch in edge detection shows as corrupted data on every word.

// File: rtl/serial_audio_rx_pkg.sv
package serial_audio_rx_pkg;

  typedef struct packed {
    logic bckFall;
    logic startVal;
    logic lrPol;
    logic syncOffset;
    logic msbFirst;
  } fmtCfg_t;

  typedef struct packed {
    logic captureBit;
    logic firstBit;
    logic bitVal;
    logic msbOrder;
    logic wordIsLeft;
    logic holdFirst;
    logic emitPair;
  } rxStrobe_t;

endpackage

// File: rtl/serial_audio_rx_ctrl.sv
module serial_audio_rx_ctrl
  import serial_audio_rx_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(WORD_W),
  localparam int CNT_W      = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bckIn,
  input  logic             lrckIn,
  input  logic             sdataIn,
  input  fmtCfg_t          fmt,
  input  logic [IDX_W-1:0] posField,
  input  logic [IDX_W-1:0] lenField,
  input  logic             cfgWrEn,
  output rxStrobe_t        strb,
  output logic [IDX_W-1:0] bitPos
);

  localparam logic [CNT_W-1:0] IDX_MAX  = '1;
  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(WORD_W - 1);

  logic [SYNC_STAGES-1:0] bckSh, lrSh, dSh;
  logic bckS, lrS, dS, bckD, lrPrev;
  logic sampleEdge, lrChange;
  logic [CNT_W-1:0] idxReg, curIdx, firstIdx, lastIdx;
  logic curOk, preBit, phaseLive, liveNow;
  logic inWin, wordDone, wordParity, havePending, pairHead;

  // input synchronisers, equal depth keeps the three lines aligned
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bckSh <= '0;
      lrSh  <= '0;
      dSh   <= '0;
      bckD  <= 1'b0;
    end else begin
      bckSh <= {bckSh[SYNC_STAGES-2:0], bckIn};
      lrSh  <= {lrSh[SYNC_STAGES-2:0], lrckIn};
      dSh   <= {dSh[SYNC_STAGES-2:0], sdataIn};
      bckD  <= bckS;
    end
  end

  assign bckS = bckSh[SYNC_STAGES-1];
  assign lrS  = lrSh[SYNC_STAGES-1];
  assign dS   = dSh[SYNC_STAGES-1];

  assign sampleEdge = fmt.bckFall ? (bckD & ~bckS) : (~bckD & bckS);
  assign lrChange   = sampleEdge && (lrS != lrPrev);

  // index of the bit being sampled right now
  always_comb begin
    if (lrChange) begin
      curIdx = '0;
      curOk  = !fmt.syncOffset;
    end else if (preBit) begin
      curIdx = '0;
      curOk  = 1'b1;
    end else begin
      curIdx = (idxReg == IDX_MAX) ? IDX_MAX : idxReg + 1'b1;
      curOk  = 1'b1;
    end
  end

  assign firstIdx = {1'b0, fmt.msbFirst ? posField : (LAST_POS - posField)};
  assign lastIdx  = firstIdx + {1'b0, lenField};
  assign liveNow  = lrChange | phaseLive;
  assign inWin    = sampleEdge && liveNow && curOk && !cfgWrEn &&
                    (curIdx >= firstIdx) && (curIdx <= lastIdx);
  assign wordDone = inWin && (curIdx == lastIdx);
  // parity of the word that opens a couple
  assign pairHead = (fmt.lrPol == fmt.startVal);

  always_comb begin
    strb            = '0;
    strb.captureBit = inWin;
    strb.firstBit   = (curIdx == firstIdx);
    strb.bitVal     = dS;
    strb.msbOrder   = fmt.msbFirst;
    strb.wordIsLeft = (lrS == fmt.lrPol);
    strb.holdFirst  = wordDone && (wordParity == pairHead);
    strb.emitPair   = wordDone && (wordParity != pairHead) && havePending;
  end

  assign bitPos = IDX_W'(curIdx - firstIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lrPrev      <= 1'b0;
      idxReg      <= IDX_MAX;
      preBit      <= 1'b0;
      phaseLive   <= 1'b0;
      wordParity  <= 1'b0;
      havePending <= 1'b0;
    end else begin
      if (sampleEdge) begin
        lrPrev <= lrS;
        idxReg <= curIdx;
        preBit <= lrChange & fmt.syncOffset;
      end
      if (cfgWrEn) begin
        phaseLive   <= 1'b0;
        wordParity  <= 1'b0;
        havePending <= 1'b0;
      end else begin
        if (lrChange) phaseLive <= 1'b1;
        if (wordDone) wordParity <= ~wordParity;
        if (strb.holdFirst) havePending <= 1'b1;
        else if (strb.emitPair) havePending <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/serial_audio_rx_dp.sv
module serial_audio_rx_dp
  import serial_audio_rx_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  input  logic [IDX_W-1:0]  bitPos,
  output logic              validOut,
  output logic [WORD_W-1:0] leftOut,
  output logic [WORD_W-1:0] rightOut
);

  logic [WORD_W-1:0] wordReg, firstReg, baseWord, nextWord;
  logic firstLeft;

  always_comb begin
    baseWord = strb.firstBit ? '0 : wordReg;
    if (strb.msbOrder) begin
      nextWord = {baseWord[WORD_W-2:0], strb.bitVal};
    end else begin
      nextWord         = baseWord;
      nextWord[bitPos] = strb.bitVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordReg   <= '0;
      firstReg  <= '0;
      firstLeft <= 1'b0;
      validOut  <= 1'b0;
      leftOut   <= '0;
      rightOut  <= '0;
    end else begin
      validOut <= strb.emitPair;
      if (strb.captureBit) wordReg <= nextWord;
      if (strb.holdFirst) begin
        firstReg  <= nextWord;
        firstLeft <= strb.wordIsLeft;
      end
      if (strb.emitPair) begin
        if (firstLeft) begin
          leftOut  <= firstReg;
          rightOut <= nextWord;
        end else begin
          leftOut  <= nextWord;
          rightOut <= firstReg;
        end
      end
    end
  end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import serial_audio_rx_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(WORD_W),
  localparam int CFG_W      = 2 * IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bckIn,
  input  logic              lrckIn,
  input  logic              sdataIn,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [CFG_W-1:0]  cfgData,
  output logic              validOut,
  output logic [WORD_W-1:0] leftOut,
  output logic [WORD_W-1:0] rightOut
);

  fmtCfg_t          fmtReg;
  logic [IDX_W-1:0] posReg, lenReg;
  rxStrobe_t        strb;
  logic [IDX_W-1:0] bitPos;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fmtReg <= '0;
      posReg <= '0;
      lenReg <= '0;
    end else if (cfgWrEn) begin
      if (!cfgSel) begin
        fmtReg.msbFirst   <= cfgData[0];
        fmtReg.syncOffset <= cfgData[1];
        fmtReg.lrPol      <= cfgData[2];
        fmtReg.startVal   <= cfgData[3];
        fmtReg.bckFall    <= cfgData[4];
      end else begin
        lenReg <= cfgData[IDX_W-1:0];
        posReg <= cfgData[CFG_W-1:IDX_W];
      end
    end
  end

  serial_audio_rx_ctrl #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .bckIn(bckIn), .lrckIn(lrckIn), .sdataIn(sdataIn),
    .fmt(fmtReg), .posField(posReg), .lenField(lenReg), .cfgWrEn(cfgWrEn),
    .strb(strb), .bitPos(bitPos)
  );

  serial_audio_rx_dp #(.WORD_W(WORD_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .bitPos(bitPos),
    .validOut(validOut), .leftOut(leftOut), .rightOut(rightOut)
  );

endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [IDX_W-1:0]  lenReg,
  input logic              validOut,
  input logic [WORD_W-1:0] leftOut,
  input logic [WORD_W-1:0] rightOut
);

  localparam logic [WORD_W:0] ONE = 1;
  logic [IDX_W:0]  shAmt;
  logic [WORD_W:0] keepWide;
  logic [WORD_W-1:0] keepMask;

  assign shAmt    = {1'b0, lenReg} + {{IDX_W{1'b0}}, 1'b1};
  assign keepWide = (ONE << shAmt) - ONE;
  assign keepMask = keepWide[WORD_W-1:0];

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    validOut |=> !validOut);

  assert_hold_outputs_R11: assert property (@(posedge clk) disable iff (!rstN)
    !validOut |-> ($stable(leftOut) && $stable(rightOut)));

  assert_resync_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgWrEn) |-> !validOut);

  assert_right_justified_R5: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> (((leftOut & ~keepMask) == '0) && ((rightOut & ~keepMask) == '0)));

endmodule

bind serial_audio_rx serial_audio_rx_chk #(.WORD_W(WORD_W)) chk_i (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .lenReg(lenReg),
  .validOut(validOut), .leftOut(leftOut), .rightOut(rightOut)
);

// File: tb/serial_audio_rx_tb_top.sv
`timescale 1ns/1ps
module serial_audio_rx_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bckIn = 1'b0, lrckIn = 1'b0, sdataIn = 1'b0;
  logic cfgWrEn = 1'b0, cfgSel = 1'b0;
  logic [9:0] cfgData = '0;
  logic validOut;
  logic [31:0] leftOut, rightOut;

  int checks = 0, fails = 0;
  int gotN = 0;
  logic [31:0] gotL [16];
  logic [31:0] gotR [16];

  // mirror of the configuration, as written by the bench
  logic cMsb = 0, cSync = 0, cLrPol = 0, cStart = 0, cBckFall = 0;
  int cPos = 0, cLen = 0;
  logic lastLevel = 1'b0;

  always #10 clk = ~clk;

  serial_audio_rx dut_i (
    .clk(clk), .rstN(rstN), .bckIn(bckIn), .lrckIn(lrckIn), .sdataIn(sdataIn),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
    .validOut(validOut), .leftOut(leftOut), .rightOut(rightOut)
  );

  always @(negedge clk) begin
    if (rstN && validOut && gotN < 16) begin
      gotL[gotN] = leftOut;
      gotR[gotN] = rightOut;
      gotN++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic writeCfg(input logic msb, input logic sync, input logic lrPol,
                          input logic startV, input logic bckFall,
                          input int pos, input int len);
    cMsb = msb; cSync = sync; cLrPol = lrPol; cStart = startV;
    cBckFall = bckFall; cPos = pos; cLen = len;
    @(negedge clk) bckIn = bckFall;
    repeat (10) @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = 1'b0;
    cfgData = {5'b0, bckFall, startV, lrPol, sync, msb};
    @(negedge clk);
    cfgSel = 1'b1;
    cfgData = {pos[4:0], len[4:0]};
    @(negedge clk);
    cfgWrEn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendBit(input logic level, input logic b);
    @(negedge clk);
    bckIn = cBckFall; lrckIn = level; sdataIn = b;
    repeat (4) @(negedge clk);
    bckIn = ~cBckFall;
    repeat (3) @(negedge clk);
  endtask

  task automatic sendPhase(input logic level, input logic [31:0] w);
    int s;
    s = cMsb ? cPos : 31 - cPos;
    for (int j = 0; j < 32; j++) begin
      int idx;
      logic b;
      idx = cSync ? j - 1 : j;
      if (idx >= s && idx <= s + cLen) begin
        b = cMsb ? w[cLen - (idx - s)] : w[idx - s];
      end else begin
        b = 1'b1;  // junk outside the window (R8)
      end
      sendBit(level, b);
    end
    lastLevel = level;
  endtask

  // send nPh phases after the last resync and check the couples (R6, R7)
  task automatic runStream(input string req, input int nPh, input logic [31:0] seed);
    logic [31:0] w [8];
    logic lvl [8];
    logic [31:0] mask;
    logic [31:0] expL [8];
    logic [31:0] expR [8];
    int expN, p0;
    mask = (cLen == 31) ? 32'hFFFF_FFFF : ((32'd1 << (cLen + 1)) - 32'd1);
    for (int k = 0; k < nPh; k++) begin
      w[k]   = (seed ^ (32'h9E37_79B9 * (k + 1))) & mask;
      lvl[k] = (~lastLevel) ^ k[0];
    end
    p0 = (cLrPol == cStart) ? 1 : 0;
    expN = 0;
    for (int k = p0; k + 1 < nPh; k += 2) begin
      if (lvl[k] == cLrPol) begin
        expL[expN] = w[k]; expR[expN] = w[k+1];
      end else begin
        expL[expN] = w[k+1]; expR[expN] = w[k];
      end
      expN++;
    end
    gotN = 0;
    for (int k = 0; k < nPh; k++) sendPhase(lvl[k], w[k]);
    repeat (20) @(negedge clk);
    check(gotN == expN, req, "couple count", gotN, expN);
    for (int i = 0; i < expN && i < gotN; i++) begin
      check(gotL[i] === expL[i], req, "left sample", gotL[i], expL[i]);
      check(gotR[i] === expR[i], req, "right sample", gotR[i], expR[i]);
    end
  endtask

  task automatic testReset();
    check(validOut === 1'b0, "R10", "valid after reset", {31'b0, validOut}, 0);
    check(leftOut === 32'b0, "R10", "left after reset", leftOut, 0);
    check(rightOut === 32'b0, "R10", "right after reset", rightOut, 0);
  endtask

  task automatic testDefaultConfig();
    // all-zero setup: 1-bit word at index 31, couples (1,2),(3,4): R10, R6
    runStream("R10", 5, 32'h1);
    runStream("R6", 5, 32'h0);
  endtask

  task automatic testMsbShortWord();
    // R2 MSB first, R4 position direct, R6 unequal -> (0,1), R1 rising edge
    writeCfg(1, 0, 1, 0, 0, 3, 15);
    runStream("R2", 4, 32'hA5C3_0F17);
  endtask

  task automatic testLsbSyncFalling();
    // R3 sync offset, R4 LSB start = 31-27 = 4, R1 falling edge, R5 24-bit
    writeCfg(0, 1, 1, 1, 1, 27, 23);
    runStream("R3", 5, 32'h5A5A_1234);
  endtask

  task automatic testFullWidth();
    // R5 full 32-bit words, R7 left on low phase when polarity is 0
    writeCfg(1, 0, 0, 1, 0, 0, 31);
    runStream("R5", 4, 32'hDEAD_BEEF);
  endtask

  task automatic testNarrowWindowJunk();
    // R8 window of 3 bits in the middle, junk ones elsewhere
    writeCfg(0, 0, 0, 1, 1, 31 - 10, 2);
    runStream("R8", 6, 32'h0000_0002);
  endtask

  task automatic testResync();
    // R9: a pending first word must not survive a configuration write
    writeCfg(1, 0, 1, 0, 0, 0, 7);
    runStream("R9", 3, 32'h0000_00C6);
    writeCfg(1, 0, 1, 0, 0, 0, 7);
    check(validOut === 1'b0, "R9", "no valid after write", {31'b0, validOut}, 0);
    runStream("R9", 2, 32'h0000_0039);
  endtask

  task automatic testPulseHold();
    // R11 outputs hold and valid stays single between couples
    logic [31:0] l0;
    int pulses;
    writeCfg(1, 0, 1, 0, 0, 0, 7);
    runStream("R11", 2, 32'h0000_0077);
    l0 = leftOut;
    pulses = 0;
    repeat (50) begin
      @(negedge clk);
      if (validOut) pulses++;
    end
    check(pulses == 0, "R11", "idle pulses", pulses, 0);
    check(leftOut === l0, "R11", "left held", leftOut, l0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    testReset();
    testDefaultConfig();
    testMsbShortWord();
    testLsbSyncFalling();
    testFullWidth();
    testNarrowWindowJunk();
    testResync();
    testPulseHold();
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule